// File: doc/BRIEF.md
# Capture-compare timer status register

This block is a 16-bit free-running timer with four input-capture channels, two compare registers and an 8-bit control/status register. The status register holds seven event flags and one control bit. The flags report a capture on each channel, a compare match on each compare register, and a counter wrap. The control bit makes a compare-A match restart the counter from zero. Software reaches every register through a simple register bus. The bus has a write strobe and a read strobe, and the read strobe lets the block know which flags software has already seen.

Each flag lives in a small three-state machine, so a flag can only be cleared by the read-then-write-zero sequence. The states are FLG_IDLE (flag low), FLG_PEND (flag high, not yet seen by a status read) and FLG_ARMED (flag high and read as 1).

- FLG_IDLE goes to FLG_PEND on a hardware event.
- FLG_PEND goes to FLG_ARMED on a status read.
- FLG_ARMED goes to FLG_IDLE on a write of 0 to that flag. If a hardware event arrives in the same cycle as that write, it goes to FLG_PEND instead.
- The low-power input sends every state to FLG_IDLE.

The capture inputs are asynchronous. Each one passes through a two-flop synchroniser and a rising-edge detector. Channels A and B can each be set to buffer mode, in which their previous capture value is moved into channel C or D. A single interrupt line combines each flag with its enable.

Top module: `capcmp_timer`

## Requirements
- R1: After reset the status register reads 0x00, and the counter, compare and capture registers all read 0. The register map is: address 0 status/control (bits 15:8 read 0), 1 counter, 2 compare A, 3 compare B, 4 capture A, 5 capture B, 6 capture C, 7 capture D.
- R2: While `lp_mode` is 1, every status flag, the read-armed state of every flag and the control bit return to 0 at the next clock edge.
- R3: Status bits 7..1 are, in order: capture A, capture B, capture C, capture D, compare A, compare B, wrap. Writing 1 to any of these bits leaves that bit unchanged.
- R4: Writing 0 to a flag clears it only if an earlier status read saw that flag as 1. A write of 0 without such a read leaves the flag at 1.
- R5: Status bit 0 is the counter-clear control bit. It can be freely written and read back.
- R6: A rising edge on `cap_in[n]` loads the counter value into that channel's capture register, three clock edges later, and sets that channel's flag. An input held high causes only one capture.
- R7: With `buf_en_a` = 1, a channel A capture first copies the old capture A value into capture C, then loads the counter into capture A. While `buf_en_a` = 1, a channel C edge still sets the capture C flag but does not load capture C.
- R8: With `buf_en_b` = 1, a channel B capture copies the old capture B value into capture D before loading the counter. Channel D behaves like channel C does under R7.
- R9: The counter advances by one on each clock edge where `cnt_en` = 1, and a bus write to address 1 loads it instead. The wrap flag sets when the counter steps from 0xFFFF to 0x0000.
- R10: On a count edge where the counter equals compare A (or compare B), the compare A (or compare B) flag sets. With the control bit at 1, a compare A match makes that count load 0 instead of incrementing.
- R11: If a hardware event and a valid software clear hit the same flag in the same cycle, the flag stays at 1. A new status read is then needed before a write of 0 clears it.
- R12: `irq` is 1 exactly when some flag is 1 and its enable is 1, with `irq_en[i]` enabling status bit i+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| lp_mode | input | 1 | Low-power mode; clears the status register |
| cnt_en | input | 1 | Count enable |
| cap_in | input | 4 | Asynchronous capture inputs, channels A..D at bits 0..3 |
| buf_en_a | input | 1 | Buffer mode for channel A (into C) |
| buf_en_b | input | 1 | Buffer mode for channel B (into D) |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational from address |
| irq_en | input | 7 | Per-flag interrupt enables |
| irq | output | 1 | Combined interrupt request |

## Verification
The assertions assume that `lp_mode` and the bus strobes are synchronous to `clk`. They also assume that `bus_rd` and `bus_wr` are never both high, and that a capture input stays high for at least as long as the synchroniser depth. The stimulus changes every input one time unit after a rising edge, and holds each capture pulse for four cycles. It issues one bus access at a time and samples outputs on the falling edge. Counter-based tests run with a known number of count edges, so the exact count value and flag set are known when the counter stops.

// File: rtl/capcmp_pkg.sv
package capcmp_pkg;
    localparam int NUM_FLAGS = 7;
    localparam int NUM_CAP   = 4;
    localparam int ADDR_W    = 3;
    localparam int CSR_W     = NUM_FLAGS + 1;

    // flag vector index j corresponds to status bit j+1
    localparam int FB_CAPA = 6;
    localparam int FB_CAPB = 5;
    localparam int FB_CAPC = 4;
    localparam int FB_CAPD = 3;
    localparam int FB_CMPA = 2;
    localparam int FB_CMPB = 1;
    localparam int FB_WRAP = 0;

    typedef enum logic [1:0] {
        FLG_IDLE  = 2'd0,
        FLG_PEND  = 2'd1,
        FLG_ARMED = 2'd2
    } flg_state_e;

    typedef enum logic [ADDR_W-1:0] {
        RA_CSR  = 3'd0,
        RA_CNT  = 3'd1,
        RA_CMPA = 3'd2,
        RA_CMPB = 3'd3,
        RA_CAPA = 3'd4,
        RA_CAPB = 3'd5,
        RA_CAPC = 3'd6,
        RA_CAPD = 3'd7
    } reg_addr_e;
endpackage

// File: rtl/capcmp_edge_sync.sv
module capcmp_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise
);
    // pipe_q[STAGES-1] is the synchronised level, pipe_q[STAGES] its delayed copy
    logic [STAGES:0] pipe_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= {pipe_q[STAGES-1:0], async_in};
    end

    assign rise = pipe_q[STAGES-1] & ~pipe_q[STAGES];
endmodule

// File: rtl/capcmp_flag_cell.sv
module capcmp_flag_cell
    import capcmp_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic lp,
    input  logic hw_set,
    input  logic rd_hit,
    input  logic sw_clr,
    output logic flag,
    output logic armed
);
    flg_state_e st_q, st_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= FLG_IDLE;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        if (lp) begin
            st_d = FLG_IDLE;
        end else begin
            unique case (st_q)
                FLG_IDLE:  if (hw_set) st_d = FLG_PEND;
                FLG_PEND:  if (rd_hit) st_d = FLG_ARMED;
                FLG_ARMED: if (sw_clr) st_d = hw_set ? FLG_PEND : FLG_IDLE;
                default:   st_d = FLG_IDLE;
            endcase
        end
    end

    always_comb begin
        flag  = (st_q != FLG_IDLE);
        armed = (st_q == FLG_ARMED);
    end
endmodule

// File: rtl/capcmp_counter.sv
module capcmp_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cnt_en,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic [W-1:0] cmp_a,
    input  logic [W-1:0] cmp_b,
    input  logic         clr_on_a,
    output logic [W-1:0] cnt,
    output logic         hit_a,
    output logic         hit_b,
    output logic         wrap
);
    localparam logic [W-1:0] CNT_MAX = '1;

    logic tick;
    assign tick  = cnt_en & ~load;
    assign hit_a = tick && (cnt == cmp_a);
    assign hit_b = tick && (cnt == cmp_b);
    assign wrap  = tick && (cnt == CNT_MAX) && !(clr_on_a && hit_a);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  cnt <= '0;
        else if (load)               cnt <= load_val;
        else if (tick) begin
            if (clr_on_a && hit_a)   cnt <= '0;
            else                     cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/capcmp_timer.sv
module capcmp_timer
    import capcmp_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 lp_mode,
    input  logic                 cnt_en,
    input  logic [NUM_CAP-1:0]   cap_in,
    input  logic                 buf_en_a,
    input  logic                 buf_en_b,
    input  logic                 bus_wr,
    input  logic                 bus_rd,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [CNT_W-1:0]     bus_wdata,
    output logic [CNT_W-1:0]     bus_rdata,
    input  logic [NUM_FLAGS-1:0] irq_en,
    output logic                 irq
);
    localparam int PAD_W = CNT_W - CSR_W;

    reg_addr_e            addr_e;
    logic [CNT_W-1:0]     cnt_q, cmp_a_q, cmp_b_q;
    logic [CNT_W-1:0]     cap_q [NUM_CAP];
    logic                 cclr_q;
    logic [NUM_CAP-1:0]   cap_evt;
    logic                 hit_a, hit_b, wrap_evt;
    logic [NUM_FLAGS-1:0] set_vec, flag_vec, armed_vec, clr_vec;
    logic                 csr_wr, csr_rd, cnt_load;

    assign addr_e   = reg_addr_e'(bus_addr);
    assign csr_wr   = bus_wr && (addr_e == RA_CSR);
    assign csr_rd   = bus_rd && (addr_e == RA_CSR);
    assign cnt_load = bus_wr && (addr_e == RA_CNT);

    for (genvar ch = 0; ch < NUM_CAP; ch++) begin : g_sync
        capcmp_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk(clk), .rst_n(rst_n), .async_in(cap_in[ch]), .rise(cap_evt[ch])
        );
    end

    capcmp_counter #(.W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .load(cnt_load),
        .load_val(bus_wdata), .cmp_a(cmp_a_q), .cmp_b(cmp_b_q),
        .clr_on_a(cclr_q), .cnt(cnt_q), .hit_a(hit_a), .hit_b(hit_b), .wrap(wrap_evt)
    );

    always_comb begin
        set_vec          = '0;
        set_vec[FB_CAPA] = cap_evt[0];
        set_vec[FB_CAPB] = cap_evt[1];
        set_vec[FB_CAPC] = cap_evt[2];
        set_vec[FB_CAPD] = cap_evt[3];
        set_vec[FB_CMPA] = hit_a;
        set_vec[FB_CMPB] = hit_b;
        set_vec[FB_WRAP] = wrap_evt;
    end

    assign clr_vec = csr_wr ? ~bus_wdata[CSR_W-1:1] : '0;

    for (genvar f = 0; f < NUM_FLAGS; f++) begin : g_flag
        capcmp_flag_cell u_flag (
            .clk(clk), .rst_n(rst_n), .lp(lp_mode), .hw_set(set_vec[f]),
            .rd_hit(csr_rd), .sw_clr(clr_vec[f]),
            .flag(flag_vec[f]), .armed(armed_vec[f])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       cclr_q <= 1'b0;
        else if (lp_mode) cclr_q <= 1'b0;
        else if (csr_wr)  cclr_q <= bus_wdata[0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmp_a_q <= '0;
            cmp_b_q <= '0;
        end else if (bus_wr) begin
            if (addr_e == RA_CMPA) cmp_a_q <= bus_wdata;
            if (addr_e == RA_CMPB) cmp_b_q <= bus_wdata;
        end
    end

    // channels A/B load the counter; C/D take either their own capture or the buffered value
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_CAP; i++) cap_q[i] <= '0;
        end else begin
            if (cap_evt[0]) cap_q[0] <= cnt_q;
            if (cap_evt[1]) cap_q[1] <= cnt_q;
            if (buf_en_a) begin
                if (cap_evt[0]) cap_q[2] <= cap_q[0];
            end else if (cap_evt[2]) begin
                cap_q[2] <= cnt_q;
            end
            if (buf_en_b) begin
                if (cap_evt[1]) cap_q[3] <= cap_q[1];
            end else if (cap_evt[3]) begin
                cap_q[3] <= cnt_q;
            end
        end
    end

    always_comb begin
        unique case (addr_e)
            RA_CSR:  bus_rdata = {{PAD_W{1'b0}}, flag_vec, cclr_q};
            RA_CNT:  bus_rdata = cnt_q;
            RA_CMPA: bus_rdata = cmp_a_q;
            RA_CMPB: bus_rdata = cmp_b_q;
            RA_CAPA: bus_rdata = cap_q[0];
            RA_CAPB: bus_rdata = cap_q[1];
            RA_CAPC: bus_rdata = cap_q[2];
            RA_CAPD: bus_rdata = cap_q[3];
        endcase
    end

    assign irq = |(flag_vec & irq_en);
endmodule

// File: rtl/capcmp_timer_chk.sv
module capcmp_timer_chk
    import capcmp_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 lp_mode,
    input logic                 irq,
    input logic                 cclr,
    input logic [NUM_FLAGS-1:0] flag_q,
    input logic [NUM_FLAGS-1:0] armed_q,
    input logic [NUM_FLAGS-1:0] set_evt,
    input logic [CNT_W-1:0]     cap_a,
    input logic [CNT_W-1:0]     cap_c,
    input logic                 cap_a_evt,
    input logic                 buf_en_a,
    input logic                 wrap_evt,
    input logic [CNT_W-1:0]     cnt
);
    assert_lp_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
        lp_mode |=> (flag_q == '0 && armed_q == '0 && !cclr));

    assert_no_unarmed_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !lp_mode |=> (($past(flag_q) & ~$past(armed_q) & ~flag_q) == '0));

    assert_set_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !lp_mode |=> (($past(set_evt) & ~flag_q) == '0));

    assert_buffer_move_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_a_evt && buf_en_a) |=> (cap_c == $past(cap_a)));

    assert_wrap_at_max_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_evt |-> (cnt == '1));

    assert_irq_needs_flag_R12: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (flag_q != '0));
endmodule

bind capcmp_timer capcmp_timer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .lp_mode(lp_mode), .irq(irq), .cclr(cclr_q),
    .flag_q(flag_vec), .armed_q(armed_vec), .set_evt(set_vec),
    .cap_a(cap_q[0]), .cap_c(cap_q[2]), .cap_a_evt(cap_evt[0]),
    .buf_en_a(buf_en_a), .wrap_evt(wrap_evt), .cnt(cnt_q)
);

// File: tb/capcmp_timer_bench.sv
module capcmp_timer_bench;
    import capcmp_pkg::*;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic        rst_n, lp_mode, cnt_en, buf_en_a, buf_en_b, bus_wr, bus_rd, irq;
    logic [3:0]  cap_in;
    logic [2:0]  bus_addr;
    logic [15:0] bus_wdata, bus_rdata;
    logic [6:0]  irq_en;
    logic        probe = 1'b0;

    capcmp_timer u_capcmp_timer (
        .clk(clk), .rst_n(rst_n), .lp_mode(lp_mode), .cnt_en(cnt_en), .cap_in(cap_in),
        .buf_en_a(buf_en_a), .buf_en_b(buf_en_b), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_en(irq_en), .irq(irq)
    );

    typedef struct {
        logic [15:0] val;
        bit          is_irq;
        string       tag;
    } exp_t;

    exp_t sb_q[$];
    int   checks = 0;
    int   errors = 0;

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    task automatic idle(input int n);
        repeat (n) begin @(posedge clk); #1; end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, input logic [15:0] e, input string tag);
        exp_t it;
        it.val = e; it.is_irq = 1'b0; it.tag = tag;
        sb_q.push_back(it);
        bus_addr = a; bus_rd = 1'b1;
        @(posedge clk); #1;
        bus_rd = 1'b0;
    endtask

    task automatic check_irq(input logic e, input string tag);
        exp_t it;
        it.val = {15'b0, e}; it.is_irq = 1'b1; it.tag = tag;
        sb_q.push_back(it);
        probe = 1'b1;
        @(posedge clk); #1;
        probe = 1'b0;
    endtask

    task automatic pulse_cap(input int ch);
        cap_in[ch] = 1'b1;
        idle(4);
        cap_in[ch] = 1'b0;
        idle(3);
    endtask

    task automatic run_ticks(input int n);
        cnt_en = 1'b1;
        idle(n);
        cnt_en = 1'b0;
    endtask

    // monitor: pops one expected item per observed read or irq probe
    initial begin
        forever begin
            @(negedge clk);
            if (bus_rd || probe) begin
                exp_t        it;
                logic [15:0] act;
                checks++;
                if (sb_q.size() == 0) begin
                    errors++;
                    $display("FAIL scoreboard empty: actual %h expected none", bus_rdata);
                end else begin
                    it  = sb_q.pop_front();
                    act = it.is_irq ? {15'b0, irq} : bus_rdata;
                    if (act !== it.val) begin
                        errors++;
                        $display("FAIL %s: actual %h expected %h", it.tag, act, it.val);
                    end
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        rst_n = 1'b0; lp_mode = 1'b0; cnt_en = 1'b0; buf_en_a = 1'b0; buf_en_b = 1'b0;
        bus_wr = 1'b0; bus_rd = 1'b0; bus_addr = '0; bus_wdata = '0; cap_in = '0; irq_en = '0;
        idle(3);
        rst_n = 1'b1;
        idle(1);

        // R1 reset state
        rd(RA_CSR,  16'h0000, "R1 status after reset");
        rd(RA_CNT,  16'h0000, "R1 counter after reset");
        rd(RA_CMPA, 16'h0000, "R1 compare A after reset");
        rd(RA_CAPD, 16'h0000, "R1 capture D after reset");

        // R6 capture on channel A
        wr(RA_CNT, 16'h1234);
        pulse_cap(0);
        rd(RA_CAPA, 16'h1234, "R6 capture A value");
        check_irq(1'b0, "R12 irq masked");
        irq_en = 7'b1000000;
        check_irq(1'b1, "R12 irq with capture A enabled");
        irq_en = '0;

        // R4 write 0 without read, R3 write 1 ignored, R5 control bit
        wr(RA_CSR, 16'h0000);
        rd(RA_CSR, 16'h0080, "R4 unread flag survives write 0");
        wr(RA_CSR, 16'h00FF);
        rd(RA_CSR, 16'h0081, "R3 write 1 no effect, R5 control set");
        wr(RA_CSR, 16'h0001);
        rd(RA_CSR, 16'h0001, "R4 armed flag cleared");
        wr(RA_CSR, 16'h0000);
        rd(RA_CSR, 16'h0000, "R5 control cleared");

        // R7 buffered channel A
        buf_en_a = 1'b1;
        wr(RA_CNT, 16'h2222);
        pulse_cap(0);
        rd(RA_CAPA, 16'h2222, "R7 capture A new value");
        rd(RA_CAPC, 16'h1234, "R7 capture C holds old A");
        rd(RA_CSR,  16'h0080, "R7 flag A set");
        wr(RA_CSR, 16'h0000);

        // R8 channel B unbuffered then buffered
        wr(RA_CNT, 16'h4444);
        pulse_cap(1);
        rd(RA_CAPB, 16'h4444, "R6 capture B value");
        buf_en_b = 1'b1;
        wr(RA_CNT, 16'h5555);
        pulse_cap(1);
        rd(RA_CAPB, 16'h5555, "R8 capture B new value");
        rd(RA_CAPD, 16'h4444, "R8 capture D holds old B");
        // R7 channel C edge under buffer mode: flag only
        wr(RA_CNT, 16'h0ABC);
        pulse_cap(2);
        rd(RA_CAPC, 16'h1234, "R7 capture C not loaded in buffer mode");
        rd(RA_CSR,  16'h0060, "R7 flags B and C set");
        wr(RA_CSR, 16'h0000);

        // R6 channels C and D unbuffered
        buf_en_a = 1'b0; buf_en_b = 1'b0;
        wr(RA_CNT, 16'h0C0C);
        pulse_cap(2);
        wr(RA_CNT, 16'h0D0D);
        pulse_cap(3);
        rd(RA_CAPC, 16'h0C0C, "R6 capture C value");
        rd(RA_CAPD, 16'h0D0D, "R6 capture D value");
        rd(RA_CSR,  16'h0030, "R6 flags C and D");
        wr(RA_CSR, 16'h0000);
        rd(RA_CSR,  16'h0000, "R4 flags C and D cleared");

        // R10 compare matches, R9 counting
        wr(RA_CMPA, 16'h0010);
        wr(RA_CMPB, 16'h0020);
        wr(RA_CNT,  16'h000E);
        run_ticks(40);
        rd(RA_CNT, 16'h0036, "R9 counter after 40 ticks");
        rd(RA_CSR, 16'h000C, "R10 both compare flags");
        wr(RA_CSR, 16'h0000);

        // R10 clear on compare A
        wr(RA_CSR, 16'h0001);
        wr(RA_CNT, 16'h000E);
        run_ticks(5);
        rd(RA_CNT, 16'h0002, "R10 counter restarted at match A");
        rd(RA_CSR, 16'h0009, "R10 flag A with control bit");
        wr(RA_CSR, 16'h0001);
        rd(RA_CSR, 16'h0001, "R4 compare flag cleared, control kept");
        wr(RA_CSR, 16'h0000);

        // R9 wrap
        wr(RA_CNT, 16'hFFFE);
        run_ticks(3);
        rd(RA_CNT, 16'h0001, "R9 counter after wrap");
        rd(RA_CSR, 16'h0002, "R9 wrap flag");
        irq_en = 7'b0000001;
        check_irq(1'b1, "R12 irq from wrap");
        irq_en = 7'b1111110;
        check_irq(1'b0, "R12 irq with wrap disabled");
        irq_en = '0;

        // R11 set and clear in the same cycle
        wr(RA_CNT, 16'hFFFF);
        bus_addr = RA_CSR; bus_wdata = 16'h0000; bus_wr = 1'b1; cnt_en = 1'b1;
        @(posedge clk); #1;
        bus_wr = 1'b0; cnt_en = 1'b0;
        wr(RA_CSR, 16'h0000);
        rd(RA_CSR, 16'h0002, "R11 set wins and needs new read");
        wr(RA_CSR, 16'h0000);
        rd(RA_CSR, 16'h0000, "R11 cleared after fresh read");

        // R2 low-power clear
        wr(RA_CSR, 16'h0001);
        pulse_cap(3);
        rd(RA_CSR, 16'h0011, "R2 state before low power");
        lp_mode = 1'b1;
        idle(1);
        lp_mode = 1'b0;
        rd(RA_CSR, 16'h0000, "R2 low power clears status");
        irq_en = 7'b1111111;
        check_irq(1'b0, "R2 no irq after low power");
        irq_en = '0;

        // R6 held input captures once
        wr(RA_CNT, 16'h6666);
        cap_in[0] = 1'b1;
        idle(4);
        wr(RA_CNT, 16'h7777);
        idle(4);
        rd(RA_CAPA, 16'h6666, "R6 held input captures once");
        cap_in[0] = 1'b0;
        idle(3);

        idle(2);
        if (sb_q.size() != 0) begin
            checks++; errors++;
            $display("FAIL scoreboard leftover: actual %0d expected 0", sb_q.size());
        end
        finish_run();
    end
endmodule